// File: doc/BRIEF.md
# CRT Timing Controller

This block generates the raster timing for a character-cell CRT display. A host reaches a set of eighteen internal registers through an index port and a data port. Those registers program the line length, the frame height, the sync pulse positions, the text row height and a hardware cursor. One character clock is one cycle of `clk`. From this clock the block counts characters along a line, scan lines within a text row, and rows within a frame.

Every cycle the block drives horizontal and vertical sync, a display-enable strobe and a 14-bit refresh address for the character memory. It also drives the scan-line number inside the current text row, and a cursor strobe that marks the character cell where the cursor sits. A read-only status port reports the blanking and vertical retrace state. A light-pen strobe input captures the refresh address on the screen at the moment the pen fires.

Top module: `crt_timing_ctrl`

## Requirements
- R1: The host decode is partial. Offsets 0, 2, 4 and 6 all reach the 5-bit index register, and a read of any of them returns the index zero-extended to 8 bits. Offsets 1, 3, 5 and 7 all reach the register that the index selects.
- R2: The start address (index 0Ch high byte, 0Dh low byte) and the cursor address (index 0Eh high, 0Fh low) can be written and read back. Each high byte keeps only bits 5:0, so it reads back with bits 7:6 clear.
- R3: Index 10h (high) and 11h (low) return the latched light-pen address, and writes to them have no effect. Data reads at any other index return FFh. Reads at offsets outside 0-7, 0Ah and 0Bh also return FFh. Read data appears on `host_rdata` one cycle after the access.
- R4: A line lasts R0+1 characters. Display enable is high for the first R1 characters of a displayed line. Hsync starts R2 characters after the line start and lasts R3 characters.
- R5: A frame lasts (R4+1)*(R9+1)+R5 scan lines: R4+1 text rows of R9+1 scan lines each, then R5 extra adjust lines. Display enable is active only during the first R6 rows.
- R6: Vsync rises on scan line 0 of row R7, with `crt_ra` equal to 0, and stays high for `VS_LINES` scan lines.
- R7: The first displayed character of a frame carries the start address. The refresh address rises by one per character, and each text row begins R1 above the previous row's base. A start address written during a frame takes effect at the next frame.
- R8: `crt_cursor` is high only in display, on the character whose refresh address equals the cursor address, and only on scan lines R10 through R11.
- R9: The status port at offset 0Ah has this layout: bit 0 is the inverse of display enable, bit 1 is the light-pen flag, bit 3 is vertical sync, and the other bits are 0. The status value reflects the outputs at the cycle of the read.
- R10: A rising edge on `lpen_stb` latches the current `crt_ma` and sets the pen flag. A read at offset 0Bh clears the flag. Any access at offset 0Ch sets the flag.
- R11: The 80-column programming (R0=71h, R1=50h, R2=5Ah, R3=0Ah, R4=1Fh, R5=06h, R6=19h, R7=1Ch, R9=07h) gives 114-character lines, 80 displayed characters, hsync 90 characters after the line start lasting 10 characters, and 262 scan lines per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 for a write access, 0 for a read access |
| host_addr | input | 4 | Host port offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| lpen_stb | input | 1 | Light-pen strobe |
| crt_hsync | output | 1 | Horizontal sync |
| crt_vsync | output | 1 | Vertical sync |
| crt_de | output | 1 | Display enable |
| crt_ma | output | 14 | Refresh memory address |
| crt_ra | output | 5 | Scan line within the current text row |
| crt_cursor | output | 1 | Cursor strobe |

## Verification
The bench builds the block with `VS_LINES` set to 4 rather than 16. This lets a tiny test raster of 10-character lines and 14-line frames hold the whole vertical sync pulse, so a single 140-cycle frame shows row stepping, the adjust lines, the cursor window and the sync placement. The same build is then reprogrammed to the 80-column values, and one full frame of about 30,000 cycles is measured against the scan-line count.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int MA_W  = 14;
  localparam int RA_W  = 5;
  localparam int REG_W = 8;

  typedef struct packed {
    logic [REG_W-1:0] h_total;
    logic [REG_W-1:0] h_disp;
    logic [REG_W-1:0] hs_pos;
    logic [REG_W-1:0] hs_wid;
    logic [REG_W-1:0] v_total;
    logic [RA_W-1:0]  v_adj;
    logic [REG_W-1:0] v_disp;
    logic [REG_W-1:0] vs_pos;
    logic [RA_W-1:0]  max_ra;
    logic [RA_W-1:0]  cur_first;
    logic [RA_W-1:0]  cur_last;
    logic [MA_W-1:0]  start_addr;
    logic [MA_W-1:0]  cur_addr;
  } crtc_cfg_t;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = REG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            lpen_stb,
  input  logic [MA_W-1:0] ma_now,
  input  logic            de_now,
  input  logic            vs_now,
  output crtc_cfg_t       cfg
);
  localparam int NREG  = 16;
  localparam int IDX_W = 5;
  localparam logic [AW-1:0] OFS_STATUS  = AW'(10);
  localparam logic [AW-1:0] OFS_PEN_CLR = AW'(11);
  localparam logic [AW-1:0] OFS_PEN_SET = AW'(12);
  localparam logic [DW-1:0] HI_MASK     = DW'((1 << (MA_W - DW)) - 1);

  logic [DW-1:0]    regs [NREG];
  logic [IDX_W-1:0] idx;
  logic [MA_W-1:0]  lp_addr;
  logic             lp_flag;
  logic             lp_d;
  logic [DW-1:0]    rd_val;
  logic [DW-1:0]    status;

  wire pair_hit = (addr[AW-1:3] == '0);
  wire acc_rd   = cs & ~we;
  wire acc_wr   = cs & we;
  wire hi_byte  = (idx[3:0] == 4'hC) || (idx[3:0] == 4'hE);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (acc_wr && pair_hit) begin
      if (!addr[0]) idx <= wdata[IDX_W-1:0];
      else if (idx < IDX_W'(NREG))
        regs[idx[3:0]] <= hi_byte ? (wdata & HI_MASK) : wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_d    <= 1'b0;
      lp_flag <= 1'b0;
      lp_addr <= '0;
    end else begin
      lp_d <= lpen_stb;
      if (lpen_stb && !lp_d) begin
        lp_addr <= ma_now;
        lp_flag <= 1'b1;
      end else if (acc_rd && addr == OFS_PEN_CLR) begin
        lp_flag <= 1'b0;
      end else if (cs && addr == OFS_PEN_SET) begin
        lp_flag <= 1'b1;
      end
    end
  end

  assign status = {{(DW-4){1'b0}}, vs_now, 1'b0, lp_flag, ~de_now};

  always_comb begin
    rd_val = '1;
    if (pair_hit) begin
      if (!addr[0]) rd_val = DW'(idx);
      else begin
        case (idx)
          IDX_W'(12): rd_val = regs[12];
          IDX_W'(13): rd_val = regs[13];
          IDX_W'(14): rd_val = regs[14];
          IDX_W'(15): rd_val = regs[15];
          IDX_W'(16): rd_val = DW'(lp_addr[MA_W-1:DW]);
          IDX_W'(17): rd_val = lp_addr[DW-1:0];
          default:    rd_val = '1;
        endcase
      end
    end else if (addr == OFS_STATUS) begin
      rd_val = status;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (acc_rd) rdata <= rd_val;
  end

  assign cfg.h_total    = regs[0];
  assign cfg.h_disp     = regs[1];
  assign cfg.hs_pos     = regs[2];
  assign cfg.hs_wid     = regs[3];
  assign cfg.v_total    = regs[4];
  assign cfg.v_adj      = regs[5][RA_W-1:0];
  assign cfg.v_disp     = regs[6];
  assign cfg.vs_pos     = regs[7];
  assign cfg.max_ra     = regs[9][RA_W-1:0];
  assign cfg.cur_first  = regs[10][RA_W-1:0];
  assign cfg.cur_last   = regs[11][RA_W-1:0];
  assign cfg.start_addr = {regs[12][MA_W-DW-1:0], regs[13]};
  assign cfg.cur_addr   = {regs[14][MA_W-DW-1:0], regs[15]};

  logic unused_bits;
  assign unused_bits = ^{regs[8], regs[5][DW-1:RA_W], regs[9][DW-1:RA_W],
                         regs[10][DW-1:RA_W], regs[11][DW-1:RA_W],
                         regs[12][DW-1:MA_W-DW], regs[14][DW-1:MA_W-DW]};
endmodule

// File: rtl/crtc_htimer.sv
module crtc_htimer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] h_disp,
  input  logic [CW-1:0] hs_pos,
  input  logic [CW-1:0] hs_wid,
  output logic [CW-1:0] hcnt,
  output logic          line_end,
  output logic          h_de,
  output logic          h_sync
);
  logic [CW:0] hs_end;

  assign line_end = (hcnt == h_total);
  assign hs_end   = {1'b0, hs_pos} + {1'b0, hs_wid};
  assign h_de     = (hcnt < h_disp);
  assign h_sync   = (hcnt >= hs_pos) && ({1'b0, hcnt} < hs_end);

  always_ff @(posedge clk) begin
    if (rst)           hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + CW'(1);
  end
endmodule

// File: rtl/crtc_vtimer.sv
module crtc_vtimer #(
  parameter int CW       = 8,
  parameter int RA_W     = 5,
  parameter int MA_W     = 14,
  parameter int VS_LINES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_end,
  input  logic [CW-1:0]   v_total,
  input  logic [RA_W-1:0] v_adj,
  input  logic [CW-1:0]   v_disp,
  input  logic [CW-1:0]   vs_pos,
  input  logic [RA_W-1:0] max_ra,
  input  logic [CW-1:0]   h_disp,
  input  logic [MA_W-1:0] start_addr,
  output logic [RA_W-1:0] ra,
  output logic            v_de,
  output logic            v_sync,
  output logic [MA_W-1:0] row_base
);
  localparam int VSC_W = $clog2(VS_LINES + 1);

  logic [CW-1:0]    row, n_row;
  logic [RA_W-1:0]  n_ra;
  logic             in_adj, n_adj;
  logic             wrap, row_adv;
  logic             vs_on;
  logic [VSC_W-1:0] vs_cnt;
  logic             vs_start;

  always_comb begin
    n_row   = row;
    n_ra    = ra;
    n_adj   = in_adj;
    wrap    = 1'b0;
    row_adv = 1'b0;
    if (!in_adj) begin
      if (ra == max_ra) begin
        n_ra = '0;
        if (row == v_total) begin
          if (v_adj == '0) begin
            n_row = '0;
            wrap  = 1'b1;
          end else begin
            n_adj = 1'b1;
          end
        end else begin
          n_row   = row + CW'(1);
          row_adv = 1'b1;
        end
      end else begin
        n_ra = ra + RA_W'(1);
      end
    end else begin
      if (ra == v_adj - RA_W'(1)) begin
        n_adj = 1'b0;
        n_row = '0;
        n_ra  = '0;
        wrap  = 1'b1;
      end else begin
        n_ra = ra + RA_W'(1);
      end
    end
  end

  assign vs_start = line_end && !n_adj && (n_row == vs_pos) && (n_ra == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      row      <= '0;
      ra       <= '0;
      in_adj   <= 1'b0;
      row_base <= '0;
    end else if (line_end) begin
      row    <= n_row;
      ra     <= n_ra;
      in_adj <= n_adj;
      if (wrap)         row_base <= start_addr;
      else if (row_adv) row_base <= row_base + MA_W'(h_disp);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_on  <= 1'b0;
      vs_cnt <= '0;
    end else if (line_end) begin
      if (vs_start) begin
        vs_on  <= 1'b1;
        vs_cnt <= '0;
      end else if (vs_on) begin
        if (vs_cnt == VSC_W'(VS_LINES - 1)) vs_on <= 1'b0;
        vs_cnt <= vs_cnt + VSC_W'(1);
      end
    end
  end

  assign v_de   = !in_adj && (row < v_disp);
  assign v_sync = vs_on;
endmodule

// File: rtl/crt_timing_ctrl.sv
module crt_timing_ctrl
  import crtc_pkg::*;
#(
  parameter int AW       = 4,
  parameter int VS_LINES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_cs,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic            lpen_stb,
  output logic            crt_hsync,
  output logic            crt_vsync,
  output logic            crt_de,
  output logic [MA_W-1:0] crt_ma,
  output logic [RA_W-1:0] crt_ra,
  output logic            crt_cursor
);
  crtc_cfg_t        cfg;
  logic [REG_W-1:0] hcnt;
  logic             line_end, h_de, h_sync;
  logic [RA_W-1:0]  ra;
  logic             v_de, v_sync;
  logic [MA_W-1:0]  row_base, ma_n;
  logic             de_n, cur_n;

  crtc_regs #(.AW(AW), .DW(REG_W)) u_regs (
    .clk(clk), .rst(rst), .cs(host_cs), .we(host_we), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .lpen_stb(lpen_stb),
    .ma_now(crt_ma), .de_now(crt_de), .vs_now(crt_vsync), .cfg(cfg)
  );

  crtc_htimer #(.CW(REG_W)) u_h (
    .clk(clk), .rst(rst), .h_total(cfg.h_total), .h_disp(cfg.h_disp),
    .hs_pos(cfg.hs_pos), .hs_wid(cfg.hs_wid), .hcnt(hcnt),
    .line_end(line_end), .h_de(h_de), .h_sync(h_sync)
  );

  crtc_vtimer #(.CW(REG_W), .RA_W(RA_W), .MA_W(MA_W), .VS_LINES(VS_LINES)) u_v (
    .clk(clk), .rst(rst), .line_end(line_end), .v_total(cfg.v_total),
    .v_adj(cfg.v_adj), .v_disp(cfg.v_disp), .vs_pos(cfg.vs_pos),
    .max_ra(cfg.max_ra), .h_disp(cfg.h_disp), .start_addr(cfg.start_addr),
    .ra(ra), .v_de(v_de), .v_sync(v_sync), .row_base(row_base)
  );

  assign ma_n  = row_base + MA_W'(hcnt);
  assign de_n  = h_de & v_de;
  assign cur_n = de_n && (ma_n == cfg.cur_addr) &&
                 (ra >= cfg.cur_first) && (ra <= cfg.cur_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      crt_hsync  <= 1'b0;
      crt_vsync  <= 1'b0;
      crt_de     <= 1'b0;
      crt_ma     <= '0;
      crt_ra     <= '0;
      crt_cursor <= 1'b0;
    end else begin
      crt_hsync  <= h_sync;
      crt_vsync  <= v_sync;
      crt_de     <= de_n;
      crt_ma     <= ma_n;
      crt_ra     <= ra;
      crt_cursor <= cur_n;
    end
  end
endmodule

// File: rtl/crtc_chk.sv
module crtc_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          host_cs,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic [7:0]    host_rdata,
  input logic          crt_de,
  input logic          crt_vsync,
  input logic          crt_cursor,
  input logic [4:0]    crt_ra
);
  // R9
  status_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (host_cs && !host_we && host_addr == AW'(10)) |=> (host_rdata[0] == !$past(crt_de)));

  // R9
  status_vret_chk: assert property (@(posedge clk) disable iff (rst)
    (host_cs && !host_we && host_addr == AW'(10)) |=> (host_rdata[3] == $past(crt_vsync)));

  // R8
  cursor_in_display_chk: assert property (@(posedge clk) disable iff (rst)
    crt_cursor |-> crt_de);

  // R6
  vsync_row_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(crt_vsync) |-> (crt_ra == 5'd0));

  // R3
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (host_cs && !host_we && host_addr == AW'(13)) |=> (host_rdata == 8'hFF));
endmodule

bind crt_timing_ctrl crtc_chk u_chk (
  .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
  .host_addr(host_addr), .host_rdata(host_rdata), .crt_de(crt_de),
  .crt_vsync(crt_vsync), .crt_cursor(crt_cursor), .crt_ra(crt_ra)
);

// File: tb/crt_timing_ctrl_tb.sv
module crt_timing_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;
  localparam int S_HS = 0, S_VS = 1, S_DE = 2, S_CUR = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_cs = 1'b0, host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        lpen_stb = 1'b0;
  logic        crt_hsync, crt_vsync, crt_de, crt_cursor;
  logic [13:0] crt_ma;
  logic [4:0]  crt_ra;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_timing_ctrl #(.AW(4), .VS_LINES(4)) u_dut (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lpen_stb(lpen_stb), .crt_hsync(crt_hsync), .crt_vsync(crt_vsync),
    .crt_de(crt_de), .crt_ma(crt_ma), .crt_ra(crt_ra), .crt_cursor(crt_cursor)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic sig(input int s);
    case (s)
      S_HS:    return crt_hsync;
      S_VS:    return crt_vsync;
      S_DE:    return crt_de;
      default: return crt_cursor;
    endcase
  endfunction

  task automatic wait_rise(input int s);
    logic p;
    p = sig(s);
    forever begin
      @(negedge clk);
      if (sig(s) && !p) break;
      p = sig(s);
    end
  endtask

  task automatic cycles_until(input int s, input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sig(s) !== lvl);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd_here(input logic [3:0] a, output logic [7:0] d);
    host_cs = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_cs = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_here(a, d);
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
    wr(4'h0, i);
    wr(4'h1, v);
  endtask

  task automatic get_reg(input logic [7:0] i, output logic [7:0] v);
    wr(4'h0, i);
    rd(4'h1, v);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R4", "reset de", crt_de, 0);
    chk("R4", "reset hsync", crt_hsync, 0);
    chk("R6", "reset vsync", crt_vsync, 0);
    chk("R8", "reset cursor", crt_cursor, 0);
    chk("R7", "reset ma", crt_ma, 0);
    chk("R3", "reset rdata", host_rdata, 0);
    rst = 1'b0;
    rd(4'hA, d);
    chk("R9", "status blank after reset", d & 8'h03, 8'h01);
  endtask

  task automatic program_small();
    set_reg(8'h00, 8'd9);  set_reg(8'h01, 8'd6);  set_reg(8'h02, 8'd7);
    set_reg(8'h03, 8'd2);  set_reg(8'h04, 8'd3);  set_reg(8'h05, 8'd2);
    set_reg(8'h06, 8'd3);  set_reg(8'h07, 8'd3);  set_reg(8'h09, 8'd2);
    set_reg(8'h0A, 8'd1);  set_reg(8'h0B, 8'd2);
    set_reg(8'h0C, 8'h01); set_reg(8'h0D, 8'h00);
    set_reg(8'h0E, 8'h01); set_reg(8'h0F, 8'h08);
    wait_rise(S_VS);
    wait_rise(S_VS);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(4'h6, 8'h0E);
    wr(4'h3, 8'h2B);
    rd(4'h4, d);
    chk("R1", "index via offset 4", d, 8'h0E);
    rd(4'h7, d);
    chk("R1", "data via offset 7", d, 8'h2B);
    wr(4'h2, 8'h0F);
    rd(4'h5, d);
    chk("R1", "data via offset 5 idx0F", d, 8'h08);
    wr(4'h0, 8'h0C);
    wr(4'h1, 8'hFF);
    rd(4'h1, d);
    chk("R2", "start hi masked", d, 8'h3F);
    get_reg(8'h0D, d);
    chk("R2", "start lo readback", d, 8'h00);
    set_reg(8'h0C, 8'h01);
    set_reg(8'h0E, 8'h01);
    get_reg(8'h0E, d);
    chk("R2", "cursor hi readback", d, 8'h01);
    get_reg(8'h05, d);
    chk("R3", "write-only idx reads FF", d, 8'hFF);
    get_reg(8'h12, d);
    chk("R3", "unused idx reads FF", d, 8'hFF);
    rd(4'hD, d);
    chk("R3", "unmapped offset reads FF", d, 8'hFF);
  endtask

  task automatic t_horizontal();
    int n, w, r;
    wait_rise(S_DE);
    cycles_until(S_HS, 1'b1, n);
    chk("R4", "hsync offset from line start", n, 7);
    cycles_until(S_HS, 1'b0, w);
    chk("R4", "hsync width", w, 2);
    cycles_until(S_HS, 1'b1, r);
    chk("R4", "line period", w + r, 10);
    wait_rise(S_DE);
    cycles_until(S_DE, 1'b0, n);
    chk("R4", "display run", n, 6);
  endtask

  task automatic t_vertical();
    int n, vs_n, de_n, cur_n, rises, first_de;
    logic pde, pvs;
    logic [13:0] ma1, ma4, ma7, ma_last, cur_ma;
    logic [4:0]  cur_ra;
    ma1 = '0; ma4 = '0; ma7 = '0; ma_last = '0; cur_ma = '0; cur_ra = '0;
    wait_rise(S_VS);
    chk("R6", "ra at vsync rise", crt_ra, 0);
    n = 0; vs_n = 1; de_n = 0; cur_n = 0; rises = 0; first_de = -1;
    pde = crt_de; pvs = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (crt_vsync && !pvs) break;
      pvs = crt_vsync;
      if (crt_vsync) vs_n++;
      if (crt_de) begin
        de_n++;
        ma_last = crt_ma;
        if (!pde) begin
          rises++;
          if (rises == 1) begin first_de = n; ma1 = crt_ma; end
          if (rises == 4) ma4 = crt_ma;
          if (rises == 7) ma7 = crt_ma;
        end
      end
      pde = crt_de;
      if (crt_cursor) begin
        if (cur_n == 0) begin cur_ma = crt_ma; cur_ra = crt_ra; end
        cur_n++;
      end
    end
    chk("R5", "frame cycles", n, 140);
    chk("R5", "display lines", rises, 9);
    chk("R5", "display cycles", de_n, 54);
    chk("R6", "vsync length", vs_n, 40);
    chk("R6", "vsync after frame start", n - first_de, 90);
    chk("R7", "first char addr", ma1, 14'h100);
    chk("R7", "row1 base", ma4, 14'h106);
    chk("R7", "row2 base", ma7, 14'h10C);
    chk("R7", "last char addr", ma_last, 14'h111);
    chk("R8", "cursor cycles", cur_n, 2);
    chk("R8", "cursor addr", cur_ma, 14'h108);
    chk("R8", "cursor first line", cur_ra, 1);
  endtask

  task automatic t_status();
    logic [7:0] d;
    logic de_o, vs_o;
    do @(negedge clk); while (!crt_vsync);
    de_o = crt_de; vs_o = crt_vsync;
    rd_here(4'hA, d);
    chk("R9", "status in vsync", d & 8'hF9, {4'b0, vs_o, 2'b0, ~de_o});
    chk("R9", "status vsync bit", d & 8'h09, 8'h09);
    do @(negedge clk); while (!crt_de);
    rd_here(4'hA, d);
    chk("R9", "status in display", d & 8'hF9, 8'h00);
    wait_rise(S_DE);
    do @(negedge clk); while (crt_de);
    rd_here(4'hA, d);
    chk("R9", "status in hblank", d & 8'hF9, 8'h01);
  endtask

  task automatic t_pen();
    logic [7:0] d;
    logic [13:0] ma_o;
    do @(negedge clk); while (!crt_de);
    ma_o = crt_ma;
    lpen_stb = 1'b1;
    get_reg(8'h10, d);
    chk("R10", "pen hi", d, {2'b0, ma_o[13:8]});
    get_reg(8'h11, d);
    chk("R10", "pen lo", d, ma_o[7:0]);
    lpen_stb = 1'b0;
    rd(4'hA, d);
    chk("R10", "flag set by strobe", d & 8'h02, 8'h02);
    rd(4'hB, d);
    rd(4'hA, d);
    chk("R10", "flag cleared by read", d & 8'h02, 8'h00);
    wr(4'hC, 8'h00);
    rd(4'hA, d);
    chk("R10", "flag preset", d & 8'h02, 8'h02);
    set_reg(8'h10, 8'h3F);
    set_reg(8'h11, 8'h5A);
    get_reg(8'h10, d);
    chk("R3", "pen hi not writable", d, {2'b0, ma_o[13:8]});
    get_reg(8'h11, d);
    chk("R3", "pen lo not writable", d, ma_o[7:0]);
  endtask

  task automatic t_start_change();
    wait_rise(S_VS);
    wait_rise(S_DE);
    chk("R7", "frame start addr", crt_ma, 14'h100);
    set_reg(8'h0C, 8'h02);
    wait_rise(S_DE);
    chk("R7", "start held mid-frame", crt_ma, 14'h100);
    wait_rise(S_VS);
    wait_rise(S_DE);
    chk("R7", "new start next frame", crt_ma, 14'h200);
    set_reg(8'h0C, 8'h01);
  endtask

  task automatic t_col80();
    int n, w, r, pvs;
    set_reg(8'h00, 8'h71); set_reg(8'h01, 8'h50); set_reg(8'h02, 8'h5A);
    set_reg(8'h03, 8'h0A); set_reg(8'h04, 8'h1F); set_reg(8'h05, 8'h06);
    set_reg(8'h06, 8'h19); set_reg(8'h07, 8'h1C); set_reg(8'h09, 8'h07);
    wait_rise(S_VS);
    n = 0; pvs = 1;
    forever begin
      @(negedge clk);
      n++;
      if (crt_vsync && pvs == 0) break;
      pvs = crt_vsync ? 1 : 0;
    end
    chk("R11", "80col frame cycles", n, 262 * 114);
    wait_rise(S_DE);
    cycles_until(S_HS, 1'b1, n);
    chk("R11", "80col hsync offset", n, 90);
    cycles_until(S_HS, 1'b0, w);
    chk("R11", "80col hsync width", w, 10);
    cycles_until(S_HS, 1'b1, r);
    chk("R11", "80col line period", w + r, 114);
    wait_rise(S_DE);
    cycles_until(S_DE, 1'b0, n);
    chk("R11", "80col display run", n, 80);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=finish", WD_CYCLES);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    program_small();
    t_regs();
    t_horizontal();
    t_vertical();
    t_status();
    t_pen();
    t_start_change();
    t_col80();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule